// File: doc/BRIEF.md
# Selectable Clock Divider Bank

This block turns one fast source clock, normally the output of an oscillator loop, into a set of slower clocks. A bank divider feeds four matched output clocks. A second divider, with its own ratio select, feeds a feedback clock and a reference clock that carry the same waveform. Each divider takes a two-bit ratio select. The bank divider also supports an odd ratio of three and still keeps the duty cycle at one half.

A path select chooses the clock that drives both dividers: the fast source, or a bypass reference. A source select picks that bypass reference from one of two reference inputs. An active-high master reset holds both dividers at their start state and forces every output low. When the reset is released, both dividers start together. A ratio change made while the block runs is taken up only when the period in progress is complete.

Top module: `clkdiv_bank`

## Requirements
- R1: The bank divider ratio follows `bank_sel`: 2'b00 divides by 3, 2'b01 by 4, 2'b10 by 6 and 2'b11 by 12.
- R2: The feedback divider ratio follows `fb_sel`: 2'b00 divides by 12, 2'b01 by 16, 2'b10 by 20 and 2'b11 by 24.
- R3: `ref_clk` has the same waveform as `fb_clk` at all times, so its period also follows `fb_sel`.
- R4: While `mr` is 1, every output reads 0. This takes effect at once, including in the middle of a high phase, and lasts for as long as `mr` stays high.
- R5: With `pll_en` = 1, the dividers count `fast_clk` and both reference inputs have no effect. With `pll_en` = 0, the dividers count the selected reference clock instead.
- R6: In bypass, `xtal_sel` = 1 selects `ref_xtal_clk` and `xtal_sel` = 0 selects `ref_ext_clk`.
- R7: For every ratio, the high time of an output is exactly half its period. For ratio 3 this uses half a source cycle.
- R8: All `N_BANK` bank outputs are identical in level and period.
- R9: A change to a ratio select while running lets the current output period finish at the old ratio. The next period uses the new ratio, with no shortened pulse.
- R10: After `mr` falls, the first rising source edge starts both dividers. An output with an even ratio rises on that edge. A ratio-3 bank output rises on the following falling source edge. No output's first transition is a fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast source clock |
| ref_ext_clk | input | 1 | External reference clock for bypass |
| ref_xtal_clk | input | 1 | Oscillator reference clock for bypass |
| pll_en | input | 1 | 1: count fast_clk, 0: count selected reference |
| xtal_sel | input | 1 | 1: oscillator reference, 0: external reference |
| mr | input | 1 | Active-high master reset |
| bank_sel | input | SEL_W | Bank divider ratio select |
| fb_sel | input | SEL_W | Feedback divider ratio select |
| bank_clk | output | N_BANK | Matched bank output clocks |
| fb_clk | output | 1 | Feedback output clock |
| ref_clk | output | 1 | Reference output clock, same as fb_clk |

## Verification
The bench times the edges of each output against its source clock. It checks the ratio-3 case most closely: a design that drops the falling-edge register gives a 2:1 duty cycle, and one that misplaces it rises a cycle late after reset. It changes a select mid-period and checks that the old period finishes. A design that reloads the ratio at once would produce a short pulse or a stretched one. It asserts reset in the middle of a high phase to catch an output that waits for a clock edge before it drops. It also measures bypass periods for both references, which catches a swapped source select.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and type codes for the selectable clock divider bank.
// Assumes ratio tables are packed with select value 0 in the least significant field.
package clkdiv_pkg;

    localparam int SEL_W_DEF  = 2;
    localparam int CNT_W_DEF  = 5;
    localparam int N_BANK_DEF = 4;
    localparam int NSEL_DEF   = 1 << SEL_W_DEF;

    // Bank ratios for select 3,2,1,0 (MSB to LSB)
    localparam logic [NSEL_DEF*CNT_W_DEF-1:0] BANK_TBL_DEF =
        {5'd12, 5'd6, 5'd4, 5'd3};
    // Feedback ratios for select 3,2,1,0 (MSB to LSB)
    localparam logic [NSEL_DEF*CNT_W_DEF-1:0] FB_TBL_DEF =
        {5'd24, 5'd20, 5'd16, 5'd12};

    // Which clock drives the dividers
    typedef enum logic {
        PATH_BYPASS = 1'b0,
        PATH_LOOP   = 1'b1
    } path_e;

    // Which reference feeds the bypass path
    typedef enum logic {
        REF_EXTERNAL = 1'b0,
        REF_OSC      = 1'b1
    } ref_src_e;

endpackage

// File: rtl/clkdiv_src_mux.sv
`timescale 1ns/1ps
// Module: picks the clock that drives both dividers.
// Assumes path and source selects change only while the dividers are held in reset,
// so a switch-over glitch never reaches a counting divider.
module clkdiv_src_mux
    import clkdiv_pkg::*;
(
    input  logic fast_clk,
    input  logic ref_ext_clk,
    input  logic ref_xtal_clk,
    input  logic pll_en,
    input  logic xtal_sel,
    output logic div_clk
);

    logic ref_pick;

    // Choose the bypass reference
    always_comb begin
        ref_pick = (ref_src_e'(xtal_sel) == REF_OSC) ? ref_xtal_clk : ref_ext_clk;
    end

    // Choose between the fast source and the bypass reference
    always_comb begin
        div_clk = (path_e'(pll_en) == PATH_LOOP) ? fast_clk : ref_pick;
    end

endmodule

// File: rtl/clkdiv_ratio_div.sv
`timescale 1ns/1ps
// Module: programmable integer clock divider with 50% duty for even and odd ratios.
// The ratio comes from a packed table indexed by sel. It is latched only at the
// terminal count, so a period in progress always completes. Odd ratios AND the
// rising-edge high phase with a copy delayed by half a source cycle.
// Assumes every table entry is at least 2. The reset is synchronous and active low;
// the output is also gated with the reset so it drops at once.
module clkdiv_ratio_div
    import clkdiv_pkg::*;
#(
    parameter int SEL_W = SEL_W_DEF,
    parameter int CNT_W = CNT_W_DEF,
    parameter logic [(1<<SEL_W)*CNT_W-1:0] RATIOS = FB_TBL_DEF
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             clk_out
);

    localparam int NSEL = 1 << SEL_W;
    localparam int CW1  = CNT_W + 1;

    // True when any ratio in the table is odd, so the half-cycle stage is needed
    function automatic logic tbl_has_odd();
        for (int i = 0; i < NSEL; i++) begin
            if (RATIOS[i*CNT_W]) return 1'b1;
        end
        return 1'b0;
    endfunction

    localparam logic HAS_ODD = tbl_has_odd();

    logic [CNT_W-1:0] sel_ratio;
    logic [CNT_W-1:0] ratio_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CW1-1:0]   half_w;
    logic             last_w;
    logic             hi_q;

    // Look up the ratio requested by the select input
    always_comb begin
        sel_ratio = RATIOS[int'(sel)*CNT_W +: CNT_W];
    end

    // Number of rising-edge cycles the high phase lasts (rounded up)
    always_comb begin
        half_w = ({1'b0, ratio_q} + CW1'(1)) >> 1;
    end

    // Terminal count of the active ratio
    always_comb begin
        last_w = (cnt_q == ratio_q - CNT_W'(1));
    end

    // Counter, active ratio and rising-edge high phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= sel_ratio;
            hi_q    <= 1'b0;
        end else begin
            hi_q <= ({1'b0, cnt_q} < half_w);
            if (last_w) begin
                cnt_q   <= '0;
                ratio_q <= sel_ratio;
            end else begin
                cnt_q   <= cnt_q + CNT_W'(1);
            end
        end
    end

    generate
        if (HAS_ODD) begin : g_odd
            logic hi_n;

            // Half-cycle delayed copy of the high phase
            always_ff @(negedge clk) begin
                if (!rst_n) begin
                    hi_n <= 1'b0;
                end else begin
                    hi_n <= hi_q;
                end
            end

            // Odd ratios trim half a cycle off the front of the high phase
            always_comb begin
                clk_out = rst_n & (ratio_q[0] ? (hi_q & hi_n) : hi_q);
            end
        end else begin : g_even
            // Even-only table: the rising-edge phase is the output
            always_comb begin
                clk_out = rst_n & hi_q;
            end
        end
    endgenerate

endmodule

// File: rtl/clkdiv_fanout.sv
`timescale 1ns/1ps
// Module: copies one divided clock onto N matched output lines.
// Assumes all copies must stay identical, so no per-line logic is inserted.
module clkdiv_fanout #(
    parameter int N = 4
)(
    input  logic         src,
    output logic [N-1:0] outs
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            // Drive one copy of the source clock
            assign outs[i] = src;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
// Module: selectable clock divider bank (top).
// One bank divider feeds N_BANK matched outputs. A feedback divider feeds the
// feedback and reference outputs. Both count the clock chosen by the source mux.
// Assumes mode and source selects change only while mr is high. The master reset
// is active high at the port and is used internally as a synchronous active-low reset.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int SEL_W  = SEL_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int N_BANK = N_BANK_DEF,
    parameter logic [(1<<SEL_W)*CNT_W-1:0] BANK_RATIOS = BANK_TBL_DEF,
    parameter logic [(1<<SEL_W)*CNT_W-1:0] FB_RATIOS   = FB_TBL_DEF
)(
    input  logic              fast_clk,
    input  logic              ref_ext_clk,
    input  logic              ref_xtal_clk,
    input  logic              pll_en,
    input  logic              xtal_sel,
    input  logic              mr,
    input  logic [SEL_W-1:0]  bank_sel,
    input  logic [SEL_W-1:0]  fb_sel,
    output logic [N_BANK-1:0] bank_clk,
    output logic              fb_clk,
    output logic              ref_clk
);

    logic       div_clk;
    logic       rst_n;
    logic       bank_div;
    logic       fb_div;
    logic [1:0] fb_pair;

    // Internal active-low reset from the active-high master reset
    assign rst_n = ~mr;

    clkdiv_src_mux u_src (
        .fast_clk     (fast_clk),
        .ref_ext_clk  (ref_ext_clk),
        .ref_xtal_clk (ref_xtal_clk),
        .pll_en       (pll_en),
        .xtal_sel     (xtal_sel),
        .div_clk      (div_clk)
    );

    clkdiv_ratio_div #(
        .SEL_W  (SEL_W),
        .CNT_W  (CNT_W),
        .RATIOS (BANK_RATIOS)
    ) u_bank_div (
        .clk     (div_clk),
        .rst_n   (rst_n),
        .sel     (bank_sel),
        .clk_out (bank_div)
    );

    clkdiv_ratio_div #(
        .SEL_W  (SEL_W),
        .CNT_W  (CNT_W),
        .RATIOS (FB_RATIOS)
    ) u_fb_div (
        .clk     (div_clk),
        .rst_n   (rst_n),
        .sel     (fb_sel),
        .clk_out (fb_div)
    );

    clkdiv_fanout #(.N(N_BANK)) u_bank_fan (
        .src  (bank_div),
        .outs (bank_clk)
    );

    clkdiv_fanout #(.N(2)) u_fb_fan (
        .src  (fb_div),
        .outs (fb_pair)
    );

    // Feedback and reference lines carry the same divided clock
    assign fb_clk  = fb_pair[0];
    assign ref_clk = fb_pair[1];

endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
// Checker: pulse-width and reset properties of the divider bank, bound to the top.
// Run lengths are counted in rising edges of the divider clock. A high run must equal
// the rounded-up half of some table ratio. A feedback low run must equal the
// rounded-down half.
module clkdiv_bank_chk #(
    parameter int SEL_W  = 2,
    parameter int CNT_W  = 5,
    parameter int N_BANK = 4,
    parameter logic [(1<<SEL_W)*CNT_W-1:0] BANK_RATIOS = clkdiv_pkg::BANK_TBL_DEF,
    parameter logic [(1<<SEL_W)*CNT_W-1:0] FB_RATIOS   = clkdiv_pkg::FB_TBL_DEF
)(
    input logic              div_clk,
    input logic              mr,
    input logic [N_BANK-1:0] bank_clk,
    input logic              fb_clk,
    input logic              ref_clk
);

    localparam int NSEL  = 1 << SEL_W;
    localparam int RUN_W = CNT_W + 1;
    localparam int TBL_W = NSEL * CNT_W;

    logic [RUN_W-1:0] fb_hi, fb_lo, bk_hi;
    logic             fb_seen;

    // Run length matches half of some table entry (rounded up or down)
    function automatic logic run_ok(input logic [RUN_W-1:0] run,
                                    input logic [TBL_W-1:0] tbl,
                                    input logic round_up);
        for (int i = 0; i < NSEL; i++) begin
            int r;
            r = int'(tbl[i*CNT_W +: CNT_W]);
            if (int'(run) == (round_up ? (r + 1) / 2 : r / 2)) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Track high and low run lengths of the outputs
    always_ff @(posedge div_clk) begin
        if (mr) begin
            fb_hi   <= '0;
            fb_lo   <= '0;
            bk_hi   <= '0;
            fb_seen <= 1'b0;
        end else begin
            fb_hi   <= fb_clk ? fb_hi + RUN_W'(1) : '0;
            fb_lo   <= fb_clk ? '0 : fb_lo + RUN_W'(1);
            bk_hi   <= bank_clk[0] ? bk_hi + RUN_W'(1) : '0;
            if (fb_clk) fb_seen <= 1'b1;
        end
    end

    // Every output is low while master reset is high
    always @(negedge div_clk) begin
        if (mr) begin
            assert_reset_low_R4: assert (bank_clk == '0 && !fb_clk && !ref_clk)
                else $error("outputs not low during master reset");
        end
    end

    // Feedback high phase is half of a legal feedback ratio
    assert_fb_high_R7: assert property (@(posedge div_clk) disable iff (mr)
        $fell(fb_clk) |-> run_ok(fb_hi, FB_RATIOS, 1'b1))
        else $error("feedback high run of illegal length");

    // Feedback low phase is half of a legal ratio once running (no runt on change)
    assert_fb_low_R9: assert property (@(posedge div_clk) disable iff (mr)
        ($rose(fb_clk) && fb_seen) |-> run_ok(fb_lo, FB_RATIOS, 1'b0))
        else $error("feedback low run of illegal length");

    // Bank high phase matches a legal bank ratio
    assert_bank_high_R1: assert property (@(posedge div_clk) disable iff (mr)
        $fell(bank_clk[0]) |-> run_ok(bk_hi, BANK_RATIOS, 1'b1))
        else $error("bank high run of illegal length");

endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .SEL_W       (SEL_W),
    .CNT_W       (CNT_W),
    .N_BANK      (N_BANK),
    .BANK_RATIOS (BANK_RATIOS),
    .FB_RATIOS   (FB_RATIOS)
) u_chk (
    .div_clk  (div_clk),
    .mr       (mr),
    .bank_clk (bank_clk),
    .fb_clk   (fb_clk),
    .ref_clk  (ref_clk)
);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected edge timings (in ps) against measured edge timings.
module test_clkdiv_bank;

    logic       fast_clk = 1'b0;
    logic       ref_ext_clk = 1'b0;
    logic       ref_xtal_clk = 1'b0;
    logic       pll_en, xtal_sel, mr;
    logic [1:0] bank_sel, fb_sel;
    logic [3:0] bank_clk;
    logic       fb_clk, ref_clk;

    always #2  fast_clk     = ~fast_clk;      // 250 MHz
    always #15 ref_ext_clk  = ~ref_ext_clk;   // 30 ns period
    always #25 ref_xtal_clk = ~ref_xtal_clk;  // 50 ns period

    clkdiv_bank i_clkdiv_bank (
        .fast_clk     (fast_clk),
        .ref_ext_clk  (ref_ext_clk),
        .ref_xtal_clk (ref_xtal_clk),
        .pll_en       (pll_en),
        .xtal_sel     (xtal_sel),
        .mr           (mr),
        .bank_sel     (bank_sel),
        .fb_sel       (fb_sel),
        .bank_clk     (bank_clk),
        .fb_clk       (fb_clk),
        .ref_clk      (ref_clk)
    );

    typedef struct {
        string req;
        string what;
        int    val;
    } exp_t;

    exp_t sb_q[$];
    int   act_q[$];
    event got;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    int   mon_idx = 0;
    logic mon;

    // Monitored output selected by index: 0..3 bank, 4 feedback, 5 reference
    always_comb begin
        case (mon_idx)
            0: mon = bank_clk[0];
            1: mon = bank_clk[1];
            2: mon = bank_clk[2];
            3: mon = bank_clk[3];
            4: mon = fb_clk;
            default: mon = ref_clk;
        endcase
    end

    function automatic int ps(input realtime d);
        return int'(d * 1000.0);
    endfunction

    function automatic int bank_ratio(input int s);
        case (s)
            0: return 3;
            1: return 4;
            2: return 6;
            default: return 12;
        endcase
    endfunction

    function automatic int fb_ratio(input int s);
        return 12 + 4 * s;
    endfunction

    task automatic push_exp(input string req, input string what, input int v);
        exp_t e;
        e.req = req; e.what = what; e.val = v;
        sb_q.push_back(e);
    endtask

    task automatic report(input int act);
        act_q.push_back(act);
        -> got;
    endtask

    // Monitor: pops results and compares against expected items
    initial begin
        forever begin
            @(got);
            while (act_q.size() > 0) begin
                int   a;
                exp_t e;
                a = act_q.pop_front();
                n_cmp++;
                if (sb_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL scoreboard: result %0d with no expected item", a);
                end else begin
                    e = sb_q.pop_front();
                    if (a != e.val) begin
                        n_bad++;
                        $display("FAIL %s %s: actual %0d expected %0d", e.req, e.what, a, e.val);
                    end
                end
            end
        end
    end

    // Measure high time and period of the selected output, in ps
    task automatic measure(input int idx, output int hi_ps, output int per_ps);
        realtime t0, t1, t2;
        mon_idx = idx;
        #1;
        @(posedge mon); t0 = $realtime;
        @(negedge mon); t1 = $realtime;
        @(posedge mon); t2 = $realtime;
        hi_ps  = ps(t1 - t0);
        per_ps = ps(t2 - t0);
    endtask

    // Restart dividers in loop mode, releasing on a falling edge of the fast clock
    task automatic restart_loop();
        mr = 1'b1;
        #40;
        @(negedge fast_clk);
        mr = 1'b0;
    endtask

    // Count samples where bank lines differ (R8) or ref differs from fb (R3)
    task automatic count_mismatch(output int bank_bad, output int ref_bad);
        bank_bad = 0;
        ref_bad  = 0;
        @(negedge fast_clk);
        #1;
        for (int k = 0; k < 60; k++) begin
            if (bank_clk != {4{bank_clk[0]}}) bank_bad++;
            if (ref_clk != fb_clk) ref_bad++;
            #4;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int      h, p, bb, rb;
        realtime t_rel, tf, tb, t0, t1, t2, t3, t4;

        mr = 1'b1; pll_en = 1'b1; xtal_sel = 1'b0; bank_sel = 2'd1; fb_sel = 2'd0;
        #40;
        // R4: reset state
        push_exp("R4", "bank_clk in reset", 0); report(int'(bank_clk));
        push_exp("R4", "fb_clk in reset", 0);   report(int'(fb_clk));
        push_exp("R4", "ref_clk in reset", 0);  report(int'(ref_clk));

        // R10: both dividers start on the first rising source edge after release
        @(negedge fast_clk);
        mr = 1'b0;
        t_rel = $realtime;
        fork
            begin @(posedge fb_clk);      tf = $realtime; end
            begin @(posedge bank_clk[0]); tb = $realtime; end
        join
        push_exp("R10", "fb first rise delay", 2000);   report(ps(tf - t_rel));
        push_exp("R10", "bank first rise delay", 2000); report(ps(tb - t_rel));

        // R10: ratio 3 rises on the falling edge after the start edge
        mr = 1'b1; bank_sel = 2'd0;
        #40;
        @(negedge fast_clk);
        mr = 1'b0;
        t_rel = $realtime;
        @(posedge bank_clk[0]);
        push_exp("R10", "ratio3 first rise delay", 4000); report(ps($realtime - t_rel));

        // R1, R7, R8: every bank ratio
        for (int s = 0; s < 4; s++) begin
            bank_sel = 2'(s);
            restart_loop();
            measure(0, h, p);
            push_exp("R1", $sformatf("bank period sel=%0d", s), bank_ratio(s) * 4000); report(p);
            push_exp("R7", $sformatf("bank high sel=%0d", s), bank_ratio(s) * 2000);   report(h);
            measure(3, h, p);
            push_exp("R8", $sformatf("bank[3] period sel=%0d", s), bank_ratio(s) * 4000); report(p);
            count_mismatch(bb, rb);
            push_exp("R8", $sformatf("bank line mismatches sel=%0d", s), 0); report(bb);
        end

        // R2, R3, R7: every feedback ratio
        for (int s = 0; s < 4; s++) begin
            fb_sel = 2'(s);
            restart_loop();
            measure(4, h, p);
            push_exp("R2", $sformatf("fb period sel=%0d", s), fb_ratio(s) * 4000); report(p);
            push_exp("R7", $sformatf("fb high sel=%0d", s), fb_ratio(s) * 2000);   report(h);
            measure(5, h, p);
            push_exp("R3", $sformatf("ref period sel=%0d", s), fb_ratio(s) * 4000); report(p);
            count_mismatch(bb, rb);
            push_exp("R3", $sformatf("ref vs fb mismatches sel=%0d", s), 0); report(rb);
        end

        // R5: in loop mode the reference selection has no effect
        xtal_sel = 1'b1; fb_sel = 2'd0;
        restart_loop();
        measure(4, h, p);
        push_exp("R5", "fb period loop mode with xtal_sel=1", 48000); report(p);
        xtal_sel = 1'b0;

        // R9: feedback ratio change 12 -> 24 mid-period
        fb_sel = 2'd0;
        restart_loop();
        @(posedge fb_clk); t0 = $realtime;
        #5 fb_sel = 2'd3;
        @(negedge fb_clk); t1 = $realtime;
        @(posedge fb_clk); t2 = $realtime;
        @(negedge fb_clk); t3 = $realtime;
        @(posedge fb_clk); t4 = $realtime;
        push_exp("R9", "fb old high", 24000);   report(ps(t1 - t0));
        push_exp("R9", "fb old period", 48000); report(ps(t2 - t0));
        push_exp("R9", "fb new high", 48000);   report(ps(t3 - t2));
        push_exp("R9", "fb new period", 96000); report(ps(t4 - t2));

        // R9: bank ratio change 4 -> 12 mid-period
        bank_sel = 2'd1;
        restart_loop();
        @(posedge bank_clk[0]); t0 = $realtime;
        #1 bank_sel = 2'd3;
        @(negedge bank_clk[0]); t1 = $realtime;
        @(posedge bank_clk[0]); t2 = $realtime;
        @(negedge bank_clk[0]); t3 = $realtime;
        @(posedge bank_clk[0]); t4 = $realtime;
        push_exp("R9", "bank old high", 8000);    report(ps(t1 - t0));
        push_exp("R9", "bank old period", 16000); report(ps(t2 - t0));
        push_exp("R9", "bank new high", 24000);   report(ps(t3 - t2));
        push_exp("R9", "bank new period", 48000); report(ps(t4 - t2));

        // R4: reset in the middle of a feedback high phase drops outputs at once
        @(posedge fb_clk);
        #3 mr = 1'b1;
        #1;
        push_exp("R4", "fb right after mr", 0);   report(int'(fb_clk));
        push_exp("R4", "ref right after mr", 0);  report(int'(ref_clk));
        push_exp("R4", "bank right after mr", 0); report(int'(bank_clk));
        #100;
        push_exp("R4", "fb while mr held", 0);   report(int'(fb_clk));
        push_exp("R4", "bank while mr held", 0); report(int'(bank_clk));

        // R5, R6: bypass with external reference (30 ns)
        pll_en = 1'b0; xtal_sel = 1'b0; fb_sel = 2'd0; bank_sel = 2'd0;
        #200;
        mr = 1'b0;
        measure(4, h, p);
        push_exp("R5", "bypass ext fb period", 360000); report(p);
        push_exp("R7", "bypass ext fb high", 180000);   report(h);
        measure(0, h, p);
        push_exp("R6", "bypass ext bank period", 90000); report(p);
        push_exp("R7", "bypass ext ratio3 high", 45000); report(h);

        // R6: bypass with oscillator reference (50 ns)
        mr = 1'b1; xtal_sel = 1'b1;
        #200;
        mr = 1'b0;
        measure(4, h, p);
        push_exp("R6", "bypass osc fb period", 600000); report(p);
        measure(0, h, p);
        push_exp("R6", "bypass osc bank period", 150000); report(p);
        push_exp("R7", "bypass osc ratio3 high", 75000);  report(h);

        #10;
        if (sb_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule